// File: doc/BRIEF.md
# Triple Watchdog Timer Peripheral

A register-mapped peripheral holding three independent 16-bit watchdog downcounters behind one simple synchronous register bus. The counters advance on a shared tick enable that an internal prescaler derives from the system clock (one tick per tenth of a second in the intended setting). Each timer carries its own expiry action. Timer 0 raises a level interrupt. Timer 1 pulses a CPU-only reset output. Timer 2 pulses a full system-reset output.

Software arms a timer by writing its limit register, which also starts the countdown. It keeps the timer alive by reading the counter register, and that read reloads the count from the limit as a side effect. There is no true stop. Instead, software sets the timer's bit in a shared mask register, which blocks the expiry action while the counter keeps running. Halfword values cross the bus byte-swapped: the low byte of the internal value travels in the upper byte lane.

Top module: `triple_wdog`

## Requirements
- R1: After reset, every counter and every limit holds 1. All running and expired flags are 0, the mask is 0, the read data is 0, and wdIrq, cpuRst and sysRst are low. A timer does not count until it has been armed.
- R2: A write to a timer's limit register (word offset 1 in its block) does four things at that edge: it loads both the limit and the counter with the written value, sets running and clears expired. Reading the limit register returns the limit and changes nothing.
- R3: A read of a timer's counter register (word offset 0) returns the count as it stood before the read edge. If the timer is running, the same read reloads the counter from the limit. On a timer that is not running, the read leaves the count unchanged.
- R4: The prescaler fires a one-clock tick every TICK_DIV clocks, and the first tick falls on the TICK_DIV-th rising edge after reset is released. A running counter changes only on a tick or on a bus access to its own block.
- R5: On a tick, a running timer whose count is 1 or 0 expires. Its count goes to 0, running clears and expired sets. Larger counts decrement by one. An expired timer holds a count of 0 until its limit is written again, so a limit of 0 expires on the first tick.
- R6: Counter and limit values cross the bus byte-swapped: bus bits 15:8 carry internal bits 7:0, and bus bits 7:0 carry internal bits 15:8.
- R7: Address map, byte addresses:
  - Timer n occupies 0x10*n. Within a block, the counter is at +0x0, the limit at +0x4 and the status at +0x8.
  - Status bit 0 is running and bit 1 is expired. All other bits read 0.
  - 0x30 holds the mask, in bits 2:0. 0x34 is a read-only summary whose bits 2:0 are the expired flags of timers 2:0.
  - Read data is registered: it appears on the clock after the read and holds until the next read.
  - Unaligned addresses (bits 1:0 not zero) and unmapped registers read 0. Writes to them, and writes to counter, status or summary registers, are ignored.
- R8: wdIrq is high exactly while timer 0 is expired and mask bit 0 is clear. Writing timer 0's limit clears it.
- R9: When timer 1 or timer 2 expires and its mask bit is clear at that edge, cpuRst or sysRst (respectively) goes high for PULSE_LEN clocks, starting on the clock after the expiry edge.
- R10: A set mask bit does not stop its timer: the timer counts and expires normally, but no reset pulse starts for that expiry.
- R11: When a limit write or counter read to a timer coincides with a tick, the bus access wins and no decrement or expiry happens at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address |
| busWdata | input | 16 | Write data (halfwords byte-swapped) |
| busRdata | output | 16 | Registered read data |
| wdIrq | output | 1 | Timer 0 interrupt level |
| cpuRst | output | 1 | Timer 1 CPU reset pulse |
| sysRst | output | 1 | Timer 2 system reset pulse |

## Verification
The bench aims at the edges where a kick or an arming write lands on the same clock as a tick. A design that let the tick win there would either expire a timer that software is feeding every cycle, or load a value one lower than the one written. It also checks that a counter read on an expired timer returns 0 without reviving it, and that a limit of 0 expires on the first tick. A design that reloaded on that read, or treated zero as "never", would miss a dead system. Masked expiry of the system-reset timer must still set the expired flag but emit no pulse. Unaligned and reserved accesses must neither alter state nor return stale data; a design that decoded them loosely would let stray writes re-arm or disarm a timer.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int NUM_TIMERS = 3;
  localparam int HALF_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 6;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CNT,
    RD_LIM,
    RD_STAT,
    RD_MASK,
    RD_SUM
  } rdSel_e;

  // Strobes from bus control to datapath
  typedef struct packed {
    logic [NUM_TIMERS-1:0] limWr;
    logic [NUM_TIMERS-1:0] cntRd;
    logic                  maskWr;
    logic                  rdEn;
    rdSel_e                rdSel;
    logic [1:0]            rdIdx;
  } strobe_t;

  function automatic logic [HALF_W-1:0] swapLanes(input logic [HALF_W-1:0] v);
    return {v[BYTE_W-1:0], v[HALF_W-1:BYTE_W]};
  endfunction
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  logic [1:0] blk;
  logic [1:0] regSel;
  logic       aligned;

  assign blk     = busAddr[ADDR_W-1:ADDR_W-2];
  assign regSel  = busAddr[ADDR_W-3:ADDR_W-4];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (busSel) begin
      stb.rdEn = !busWrite;
      if (aligned) begin
        if (blk == 2'd3) begin
          if (busWrite) begin
            stb.maskWr = (regSel == 2'd0);
          end else begin
            case (regSel)
              2'd0:    stb.rdSel = RD_MASK;
              2'd1:    stb.rdSel = RD_SUM;
              default: stb.rdSel = RD_NONE;
            endcase
          end
        end else begin
          stb.rdIdx = blk;
          for (int i = 0; i < NUM_TIMERS; i++) begin
            if (blk == 2'(i)) begin
              stb.limWr[i] = busWrite && (regSel == 2'd1);
              stb.cntRd[i] = !busWrite && (regSel == 2'd0);
            end
          end
          if (!busWrite) begin
            case (regSel)
              2'd0:    stb.rdSel = RD_CNT;
              2'd1:    stb.rdSel = RD_LIM;
              2'd2:    stb.rdSel = RD_STAT;
              default: stb.rdSel = RD_NONE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int TICK_DIV  = 5000000,
  parameter int PULSE_LEN = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           stb,
  input  logic [HALF_W-1:0]                 wdata,
  output logic [HALF_W-1:0]                 rdata,
  output logic                              wdIrq,
  output logic                              cpuRst,
  output logic                              sysRst,
  output logic                              tickEn,
  output logic [NUM_TIMERS-1:0]             runVec,
  output logic [NUM_TIMERS-1:0]             expVec,
  output logic [NUM_TIMERS-1:0]             maskVec,
  output logic [NUM_TIMERS-1:0][HALF_W-1:0] cntVec
);
  localparam int PC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PL_W = $clog2(PULSE_LEN + 1);
  localparam logic [PC_W-1:0]   PC_LAST  = PC_W'(TICK_DIV - 1);
  localparam logic [PL_W-1:0]   PL_LOAD  = PL_W'(PULSE_LEN);
  localparam logic [HALF_W-1:0] CNT_INIT = HALF_W'(1);

  logic [PC_W-1:0]                   preCnt;
  logic [HALF_W-1:0]                 wrVal;
  logic [NUM_TIMERS-1:0][HALF_W-1:0] limVec;
  logic [NUM_TIMERS-1:0]             fire;
  logic [NUM_TIMERS-1:0]             actOut;

  assign wrVal = swapLanes(wdata);

  // Tick prescaler
  assign tickEn = (preCnt == PC_LAST);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       preCnt <= '0;
    else if (tickEn) preCnt <= '0;
    else             preCnt <= preCnt + 1'b1;
  end

  // Shared action mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           maskVec <= '0;
    else if (stb.maskWr) maskVec <= wdata[NUM_TIMERS-1:0];
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    logic [HALF_W-1:0] cntQ;
    logic [HALF_W-1:0] limQ;
    logic              runQ;
    logic              expQ;

    assign fire[t] = runQ && tickEn && !stb.limWr[t] && !stb.cntRd[t] &&
                     (cntQ <= CNT_INIT);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= CNT_INIT;
        limQ <= CNT_INIT;
        runQ <= 1'b0;
        expQ <= 1'b0;
      end else if (stb.limWr[t]) begin
        cntQ <= wrVal;
        limQ <= wrVal;
        runQ <= 1'b1;
        expQ <= 1'b0;
      end else if (stb.cntRd[t]) begin
        if (runQ) cntQ <= limQ;
      end else if (fire[t]) begin
        cntQ <= '0;
        runQ <= 1'b0;
        expQ <= 1'b1;
      end else if (runQ && tickEn) begin
        cntQ <= cntQ - 1'b1;
      end
    end

    assign cntVec[t] = cntQ;
    assign limVec[t] = limQ;
    assign runVec[t] = runQ;
    assign expVec[t] = expQ;

    if (t == 0) begin : g_irq
      assign actOut[t] = expQ && !maskVec[t];
    end else begin : g_pulse
      logic [PL_W-1:0] pulseQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        pulseQ <= '0;
        else if (fire[t] && !maskVec[t])  pulseQ <= PL_LOAD;
        else if (pulseQ != '0)            pulseQ <= pulseQ - 1'b1;
      end
      assign actOut[t] = (pulseQ != '0);
    end
  end

  assign wdIrq  = actOut[0];
  assign cpuRst = actOut[1];
  assign sysRst = actOut[2];

  // Read path
  logic [HALF_W-1:0] selCnt;
  logic [HALF_W-1:0] selLim;
  logic              selRun;
  logic              selExp;

  always_comb begin
    selCnt = '0;
    selLim = '0;
    selRun = 1'b0;
    selExp = 1'b0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (stb.rdIdx == 2'(i)) begin
        selCnt = cntVec[i];
        selLim = limVec[i];
        selRun = runVec[i];
        selExp = expVec[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (stb.rdEn) begin
      case (stb.rdSel)
        RD_CNT:  rdata <= swapLanes(selCnt);
        RD_LIM:  rdata <= swapLanes(selLim);
        RD_STAT: rdata <= HALF_W'({selExp, selRun});
        RD_MASK: rdata <= HALF_W'(maskVec);
        RD_SUM:  rdata <= HALF_W'(expVec);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/triple_wdog.sv
module triple_wdog
  import wdog_pkg::*;
#(
  parameter int TICK_DIV  = 5000000,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [HALF_W-1:0] busWdata,
  output logic [HALF_W-1:0] busRdata,
  output logic              wdIrq,
  output logic              cpuRst,
  output logic              sysRst
);
  strobe_t                           stb;
  logic                              tickEn;
  logic [NUM_TIMERS-1:0]             runVec;
  logic [NUM_TIMERS-1:0]             expVec;
  logic [NUM_TIMERS-1:0]             maskVec;
  logic [NUM_TIMERS-1:0][HALF_W-1:0] cntVec;

  wdog_ctrl u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .stb     (stb)
  );

  wdog_datapath #(
    .TICK_DIV (TICK_DIV),
    .PULSE_LEN(PULSE_LEN)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .wdIrq  (wdIrq),
    .cpuRst (cpuRst),
    .sysRst (sysRst),
    .tickEn (tickEn),
    .runVec (runVec),
    .expVec (expVec),
    .maskVec(maskVec),
    .cntVec (cntVec)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic                              busSel,
  input logic                              busWrite,
  input logic [ADDR_W-1:0]                 busAddr,
  input logic                              wdIrq,
  input logic                              cpuRst,
  input logic                              sysRst,
  input logic                              tickEn,
  input logic [NUM_TIMERS-1:0]             runVec,
  input logic [NUM_TIMERS-1:0]             expVec,
  input logic [NUM_TIMERS-1:0]             maskVec,
  input logic [NUM_TIMERS-1:0][HALF_W-1:0] cntVec
);
  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    a_r2_limit_arms: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWrite && busAddr == 6'(i * 16 + 4)) |=> (runVec[i] && !expVec[i]));

    a_r5_run_exp_exclusive: assert property (@(posedge clk) disable iff (!rstN)
      !(runVec[i] && expVec[i]));

    a_r5_expired_at_zero: assert property (@(posedge clk) disable iff (!rstN)
      expVec[i] |-> (cntVec[i] == '0));
  end

  a_r4_quiet_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !busSel) |=> $stable(cntVec));

  a_r8_irq_needs_expiry: assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |-> expVec[0]);

  a_r9_cpu_pulse_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRst) |-> (expVec[1] && $past(runVec[1])));

  a_r10_masked_no_sys_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(expVec[2]) && $past(maskVec[2]) && !$past(sysRst)) |-> !sysRst);
endmodule

bind triple_wdog wdog_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .wdIrq   (wdIrq),
  .cpuRst  (cpuRst),
  .sysRst  (sysRst),
  .tickEn  (tickEn),
  .runVec  (runVec),
  .expVec  (expVec),
  .maskVec (maskVec),
  .cntVec  (cntVec)
);

// File: tb/test_triple_wdog.sv
`timescale 1ns/1ps
module test_triple_wdog;
  localparam int DIV  = 6;
  localparam int PLEN = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        wdIrq, cpuRst, sysRst;

  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 1'b0;
  string rdTag = "R1";

  always #2.5 clk = ~clk;

  triple_wdog #(.TICK_DIV(DIV), .PULSE_LEN(PLEN)) i_triple_wdog (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .wdIrq(wdIrq), .cpuRst(cpuRst), .sysRst(sysRst)
  );

  // Reference model from the requirements
  logic [15:0] mCnt [3];
  logic [15:0] mLim [3];
  logic [2:0]  mRun, mExp, mMask;
  int          mPul [3];
  int          mPc;
  logic [15:0] mRd;

  function automatic logic [15:0] sw(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [15:0] readModel(input logic [1:0] b, input logic [1:0] g);
    if (b == 2'd3) begin
      if (g == 2'd0) return {13'd0, mMask};
      if (g == 2'd1) return {13'd0, mExp};
      return 16'd0;
    end
    case (g)
      2'd0:    return sw(mCnt[b]);
      2'd1:    return sw(mLim[b]);
      2'd2:    return {14'd0, mExp[b], mRun[b]};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic tk, rd, wr, al, limW, cR;
    logic [1:0] b, g;
    logic [2:0] fire;
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        mCnt[i] <= 16'd1; mLim[i] <= 16'd1; mPul[i] <= 0;
      end
      mRun <= '0; mExp <= '0; mMask <= '0; mPc <= 0; mRd <= '0;
    end else begin
      tk = (mPc == DIV - 1);
      mPc <= tk ? 0 : mPc + 1;
      al = (busAddr[1:0] == 2'b00);
      b = busAddr[5:4];
      g = busAddr[3:2];
      rd = busSel && !busWrite;
      wr = busSel && busWrite && al;
      if (rd) mRd <= al ? readModel(b, g) : 16'd0;
      fire = '0;
      for (int i = 0; i < 3; i++) begin
        limW = wr && (b == 2'(i)) && (g == 2'd1);
        cR   = rd && al && (b == 2'(i)) && (g == 2'd0);
        if (limW) begin
          mLim[i] <= sw(busWdata); mCnt[i] <= sw(busWdata);
          mRun[i] <= 1'b1; mExp[i] <= 1'b0;
        end else if (cR) begin
          if (mRun[i]) mCnt[i] <= mLim[i];
        end else if (tk && mRun[i]) begin
          if (mCnt[i] <= 16'd1) begin
            mCnt[i] <= 16'd0; mRun[i] <= 1'b0; mExp[i] <= 1'b1; fire[i] = 1'b1;
          end else begin
            mCnt[i] <= mCnt[i] - 16'd1;
          end
        end
      end
      if (wr && b == 2'd3 && g == 2'd0) mMask <= busWdata[2:0];
      for (int i = 1; i < 3; i++) begin
        if (fire[i] && !mMask[i]) mPul[i] <= PLEN;
        else if (mPul[i] > 0)     mPul[i] <= mPul[i] - 1;
      end
    end
  end

  task automatic cmp(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    cmp(rdTag, busRdata, mRd);
    cmp("R8 irq", {15'd0, wdIrq}, {15'd0, mExp[0] && !mMask[0]});
    cmp("R9 cpuRst", {15'd0, cpuRst}, {15'd0, mPul[1] != 0});
    cmp("R9 sysRst", {15'd0, sysRst}, {15'd0, mPul[2] != 0});
    busSel = s; busWrite = w; busAddr = a; busWdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 6'd0, 16'd0);
  endtask

  task automatic rdReg(input logic [5:0] a, input string tag);
    rdTag = tag;
    step(1'b1, 1'b0, a, 16'd0);
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [15:0] d);
    step(1'b1, 1'b1, a, d);
  endtask

  task automatic expectRd(input logic [5:0] a, input string tag, input logic [15:0] v);
    rdReg(a, tag);
    idle(1);
    cmp(tag, busRdata, v);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    cmp("R1 outputs", {13'd0, wdIrq, cpuRst, sysRst}, 16'd0);
    cmp("R1 rdata", busRdata, 16'd0);
    expectRd(6'h00, "R1 cnt0", 16'h0100);
    expectRd(6'h14, "R1 lim1", 16'h0100);
    expectRd(6'h28, "R1 stat2", 16'h0000);
    expectRd(6'h30, "R1 mask", 16'h0000);
    idle(3 * DIV);
    expectRd(6'h20, "R1 idle cnt2", 16'h0100);

    // R2 / R6 arming and lane swap
    wrReg(6'h04, 16'h3412);
    expectRd(6'h04, "R6 lim0 swap", 16'h3412);
    expectRd(6'h04, "R2 lim read no side effect", 16'h3412);
    expectRd(6'h08, "R2 running", 16'h0001);

    // R7 ignored accesses
    wrReg(6'h00, 16'h0500);
    wrReg(6'h06, 16'h0100);
    wrReg(6'h0C, 16'h0100);
    expectRd(6'h04, "R7 ignored writes", 16'h3412);
    expectRd(6'h3C, "R7 unmapped", 16'h0000);
    expectRd(6'h05, "R7 unaligned", 16'h0000);

    // R5 / R8 / R3 expiry of timer 0
    wrReg(6'h04, 16'h0200);
    idle(3 * DIV);
    cmp("R8 irq after expiry", {15'd0, wdIrq}, 16'd1);
    expectRd(6'h08, "R5 expired", 16'h0002);
    expectRd(6'h00, "R3 no reload when expired", 16'h0000);
    expectRd(6'h08, "R3 still expired", 16'h0002);
    wrReg(6'h04, 16'h0000);
    idle(1);
    cmp("R8 irq cleared", {15'd0, wdIrq}, 16'd0);
    idle(DIV + 1);
    expectRd(6'h08, "R5 zero limit expires", 16'h0002);

    // R9 CPU reset pulse length
    wrReg(6'h14, 16'h0100);
    hi = 0;
    for (int k = 0; k < 3 * DIV; k++) begin
      idle(1);
      hi += int'(cpuRst);
    end
    cmp("R9 pulse length", 16'(hi), 16'(PLEN));

    // R10 masked system reset
    wrReg(6'h30, 16'h0004);
    wrReg(6'h24, 16'h0100);
    hi = 0;
    for (int k = 0; k < 3 * DIV; k++) begin
      idle(1);
      hi += int'(sysRst);
    end
    cmp("R10 no sys pulse", 16'(hi), 16'd0);
    expectRd(6'h28, "R10 expired while masked", 16'h0002);
    rdReg(6'h34, "R7 summary");
    idle(1);
    cmp("R7 summary bit2", busRdata & 16'h0004, 16'h0004);

    // R11 kick every cycle beats the tick
    wrReg(6'h30, 16'h0000);
    wrReg(6'h24, 16'h0100);
    for (int k = 0; k < 4 * DIV; k++) rdReg(6'h20, "R11 kick");
    idle(1);
    expectRd(6'h28, "R11 kicked timer alive", 16'h0001);

    // R4 count observed mid-interval
    wrReg(6'h14, 16'h0900);
    idle(2 * DIV);
    rdReg(6'h10, "R4 count");
    idle(1);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [1:0] t;
      logic [15:0] v;
      r = $urandom_range(0, 99);
      t = 2'($urandom_range(0, 2));
      v = ($urandom_range(0, 9) == 0) ? 16'($urandom_range(8, 40)) : 16'($urandom_range(0, 7));
      if (r < 35)      idle(1);
      else if (r < 55) rdReg({t, 2'd0, 2'b00}, "R3");
      else if (r < 68) wrReg({t, 2'd1, 2'b00}, sw(v));
      else if (r < 78) rdReg({t, 2'd2, 2'b00}, "R5");
      else if (r < 83) rdReg({t, 2'd1, 2'b00}, "R2");
      else if (r < 87) wrReg(6'h30, ($urandom_range(0, 1) == 0) ? 16'd0 : 16'($urandom_range(0, 7)));
      else if (r < 91) rdReg({2'd3, 2'($urandom_range(0, 3)), 2'b00}, "R7");
      else if (r < 95) step(1'b1, 1'($urandom_range(0, 1)),
                            {2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(1, 3))},
                            16'($urandom));
      else             wrReg({t, ($urandom_range(0, 1) == 0) ? 2'd0 : 2'd2, 2'b00}, 16'($urandom));
    end
    idle(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule